// File: doc/BRIEF.md
# Stereo-Paired Receive FIFO With Overflow Capture

This block buffers audio words coming out of a serial-to-parallel converter until a consumer (a DMA engine or a processor read path) takes them. Each incoming word carries a tag that marks it as a left or right sample. Storage for nine words sits in a single ring. One of the nine stands for the converter's holding stage and eight for the FIFO proper. When the ring cannot take a word, that word is thrown away and the words already stored are kept.

In paired mode the block admits or refuses words only as whole left/right pairs, so the consumer always reads an alternating left, right, left, right stream. A left word claims room for itself and its partner. The right word that follows is stored only if its left was stored. In unpaired mode, meant for the 32-bit I2S and left-justified formats, each word stands on its own. Any refused word sets a sticky overflow flag. Software clears the flag with a write-one strobe. The flag drives a level interrupt through an enable bit.

The write side has no ready signal. A word is offered for one cycle with `wr_valid` and is either taken or dropped, never stalled. The read side follows valid/ready rules: `fifo_empty` low means a word is available, and `rd_en` is the consumer's ready. A transfer happens on a clock edge where both hold, and the word appears on `rd_data` after that edge. Storage is freed at that same edge.

Top module: `sfifo_top`

## Requirements
- R1: A word offered when no location is free, and no read transfer occurs in the same cycle, is discarded; stored words and their order are unchanged.
- R2: In paired mode (`unpaired_mode` = 0), a left word (`wr_right` = 0) is stored only if at least two locations are free, counting a location freed by a read transfer in the same cycle.
- R3: In paired mode, a right word (`wr_right` = 1) is stored if and only if the most recent offered word was a left word that was stored.
- R4: In unpaired mode (`unpaired_mode` = 1), every offered word is stored whenever at least one location is free, whatever its tag.
- R5: Any offered word that is discarded sets `ovf_sticky` at the same clock edge.
- R6: `ovf_sticky` stays set until a cycle with `ovf_clr` = 1 and no discard; a read transfer does not clear it, and a discard in the clearing cycle keeps it set.
- R7: `ovf_irq` is high exactly when `ovf_sticky` is high and `ovf_irq_en` is high.
- R8: The ring holds at most 9 words (FIFO_DEPTH + STAGE_DEPTH), and stored words leave in arrival order, one per read transfer, on `rd_data` after the transferring edge.
- R9: A read request while `fifo_empty` is high transfers nothing, and `rd_data` keeps its previous value.
- R10: On a full ring, a read transfer and an offered word in the same cycle let the word be stored.
- R11: Once reads free enough room, words are accepted again without any other action.
- R12: After reset, `fifo_empty` = 1, `ovf_sticky` = 0, `ovf_irq` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | An incoming word is offered this cycle |
| wr_data | input | DATA_W | Incoming word |
| wr_right | input | 1 | Channel tag: 0 left, 1 right |
| unpaired_mode | input | 1 | 0 paired admission, 1 single-word admission |
| rd_en | input | 1 | Consumer ready; takes one word when not empty |
| rd_data | output | DATA_W | Last word read out |
| fifo_empty | output | 1 | No stored word available |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| ovf_clr | input | 1 | Write-one-to-clear of the overflow flag |
| ovf_sticky | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt, level |

## Verification
The assertion that an accepted right word always finds room relies on the tags alternating in paired mode and on the mode staying fixed between a left word and its partner. The random phase keeps to this. It holds the mode steady over long stretches, flips the tag only when a word is offered, and restarts on a left tag whenever paired mode is entered. The directed corner cases also honour it, apart from a stray right word offered after its left was refused, which the admission rule covers.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic {
    PAIR_MODE   = 1'b0,
    SINGLE_MODE = 1'b1
  } admit_mode_e;

  typedef struct packed {
    logic take;
    logic toss;
  } admit_t;
endpackage

// File: rtl/sfifo_admit.sv
module sfifo_admit
  import sfifo_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_right,
  input  admit_mode_e      mode,
  input  logic [CNT_W-1:0] free_slots,
  output admit_t           verdict
);
  logic pair_open;

  always_comb begin
    verdict = '0;
    if (wr_valid) begin
      if (mode == SINGLE_MODE)
        verdict.take = (free_slots != '0);
      else if (!wr_right)
        verdict.take = (free_slots >= CNT_W'(2));
      else
        verdict.take = pair_open;
      verdict.toss = !verdict.take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pair_open <= 1'b0;
    else if (wr_valid)
      pair_open <= (mode == PAIR_MODE) && !wr_right && verdict.take;
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DATA_W = 24,
  parameter int TOTAL  = 9,
  localparam int CNT_W = $clog2(TOTAL + 1),
  localparam int PTR_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              fifo_empty,
  output logic              rd_fire,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] ring [TOTAL];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(TOTAL - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifo_empty = (count == '0);
  assign rd_fire    = rd_en && !fifo_empty;

  always_ff @(posedge clk) begin
    if (push) ring[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (rd_fire) begin
        rd_ptr  <= bump(rd_ptr);
        rd_data <= ring[rd_ptr];
      end
      case ({push, rd_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(TOTAL) || rd_fire)); // R1
  AST_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(TOTAL)); // R8
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && rd_en) |=> $stable(rd_data)); // R9
endmodule

// File: rtl/sfifo_status.sv
module sfifo_status (
  input  logic clk,
  input  logic rst_n,
  input  logic toss,
  input  logic ovf_clr,
  input  logic ovf_irq_en,
  output logic ovf_sticky,
  output logic ovf_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_sticky <= 1'b0;
    else if (toss)
      ovf_sticky <= 1'b1;
    else if (ovf_clr)
      ovf_sticky <= 1'b0;
  end

  assign ovf_irq = ovf_sticky && ovf_irq_en;

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    toss |=> ovf_sticky); // R5
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky); // R6
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top
  import sfifo_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int FIFO_DEPTH  = 8,
  parameter int STAGE_DEPTH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_right,
  input  logic              unpaired_mode,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              fifo_empty,
  input  logic              ovf_irq_en,
  input  logic              ovf_clr,
  output logic              ovf_sticky,
  output logic              ovf_irq
);
  localparam int TOTAL = FIFO_DEPTH + STAGE_DEPTH;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] count, free_slots;
  logic             rd_fire;
  admit_t           verdict;
  admit_mode_e      mode;

  assign mode       = admit_mode_e'(unpaired_mode);
  assign free_slots = CNT_W'(TOTAL) - count + CNT_W'(rd_fire);

  sfifo_admit #(.CNT_W(CNT_W)) u_admit (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_right(wr_right),
    .mode(mode), .free_slots(free_slots), .verdict(verdict)
  );

  sfifo_store #(.DATA_W(DATA_W), .TOTAL(TOTAL)) u_store (
    .clk(clk), .rst_n(rst_n), .push(verdict.take), .push_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .rd_fire(rd_fire), .count(count)
  );

  sfifo_status u_status (
    .clk(clk), .rst_n(rst_n), .toss(verdict.toss), .ovf_clr(ovf_clr),
    .ovf_irq_en(ovf_irq_en), .ovf_sticky(ovf_sticky), .ovf_irq(ovf_irq)
  );

  AST_RIGHT_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict.take && wr_right && mode == PAIR_MODE)
      |-> (count < CNT_W'(TOTAL) || rd_fire)); // R3
  AST_LEFT_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict.take && !wr_right && mode == PAIR_MODE)
      |-> (count < CNT_W'(TOTAL - 1) || (rd_fire && count < CNT_W'(TOTAL)))); // R2
endmodule

// File: tb/sfifo_top_test.sv
`timescale 1ns/1ps
module sfifo_top_test;
  localparam int DW = 24;
  localparam int TOTAL = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_right = 0, unpaired_mode = 0, rd_en = 0;
  logic ovf_irq_en = 0, ovf_clr = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic fifo_empty, ovf_sticky, ovf_irq;

  always #2.5 clk = ~clk;

  sfifo_top #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_right(wr_right), .unpaired_mode(unpaired_mode), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .ovf_irq_en(ovf_irq_en),
    .ovf_clr(ovf_clr), .ovf_sticky(ovf_sticky), .ovf_irq(ovf_irq)
  );

  int vectors = 0, misses = 0;
  bit done = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] m_rd = '0;
  bit m_open = 0, m_sticky = 0;

  task automatic check(input string tag, input string name,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  function automatic bit admit(input bit wv, input bit rt, input bit um, input int free);
    if (!wv) return 0;
    if (um) return free >= 1;      // R4
    if (!rt) return free >= 2;     // R2
    return m_open;                 // R3
  endfunction

  task automatic step(input bit wv, input bit rt, input logic [DW-1:0] d,
                      input bit rd, input bit clr, input bit en, input bit um,
                      input string tag);
    bit rf, acc;
    int free;
    @(negedge clk);
    wr_valid = wv; wr_right = rt; wr_data = d; rd_en = rd;
    ovf_clr = clr; ovf_irq_en = en; unpaired_mode = um;
    rf = rd && (mq.size() > 0);
    free = TOTAL - mq.size() + (rf ? 1 : 0);
    acc = admit(wv, rt, um, free);
    if (rf) m_rd = mq.pop_front();
    if (acc) mq.push_back(d);
    if (wv) m_open = !um && !rt && acc;
    m_sticky = (wv && !acc) ? 1'b1 : (clr ? 1'b0 : m_sticky);
    @(posedge clk);
    #1;
    check(tag, "rd_data", 32'(rd_data), 32'(m_rd));
    check(tag, "fifo_empty", 32'(fifo_empty), 32'(mq.size() == 0));
    check(tag, "ovf_sticky", 32'(ovf_sticky), 32'(m_sticky));
    check(tag, "ovf_irq", 32'(ovf_irq), 32'(m_sticky && en));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    bit um, nr;
    repeat (3) @(posedge clk);
    #1;
    check("R12", "rd_data", 32'(rd_data), 0);
    check("R12", "fifo_empty", 32'(fifo_empty), 1);
    check("R12", "ovf_sticky", 32'(ovf_sticky), 0);
    check("R12", "ovf_irq", 32'(ovf_irq), 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 4; i++) begin
      step(1, 0, DW'(24'h100 + 2*i), 0, 0, 0, 0, "R8");
      step(1, 1, DW'(24'h101 + 2*i), 0, 0, 0, 0, "R8");
    end
    step(1, 0, 24'h200, 0, 0, 0, 0, "R2");   // one free: left refused, flag set
    step(1, 1, 24'h201, 0, 0, 0, 0, "R3");   // partner refused
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 1, 0, "R6");         // read leaves flag set
    step(1, 0, 24'h300, 0, 0, 1, 0, "R11");
    step(1, 1, 24'h301, 0, 0, 1, 0, "R11");
    step(1, 0, 24'h400, 0, 0, 1, 1, "R1");   // full, unpaired, dropped
    step(1, 1, 24'h401, 1, 0, 1, 1, "R10");  // full with read: stored
    step(1, 0, 24'h402, 0, 1, 1, 1, "R6");   // clear loses to discard
    step(0, 0, 0, 0, 1, 1, 1, "R6");
    step(0, 0, 0, 1, 0, 1, 0, "R8");
    step(1, 0, 24'h500, 1, 0, 1, 0, "R2");   // one free plus read: left fits
    step(1, 1, 24'h501, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 1, 0, 1, 1, "R8");
    step(1, 1, 24'h600, 0, 0, 1, 1, "R4");
    step(1, 0, 24'h601, 0, 0, 1, 1, "R1");
    for (int i = 0; i < TOTAL; i++) step(0, 0, 0, 1, 0, 1, 0, "R8");
    step(0, 0, 0, 1, 0, 1, 0, "R9");
    step(0, 0, 0, 1, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 0, "R6");

    void'($urandom(32'd7041));
    um = 0; nr = 0;
    for (int i = 0; i < 4000; i++) begin
      bit wv;
      if (i % 500 == 0) begin um = ($urandom % 2) == 1; nr = 0; end
      wv = ($urandom % 100) < 60;
      step(wv, um ? ($urandom % 2) == 1 : nr, DW'($urandom),
           ($urandom % 100) < 45, ($urandom % 100) < 3,
           ($urandom % 2) == 1, um, um ? "R4" : "R3");
      if (wv && !um) nr = !nr;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule